// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a bank of already-synchronized input pins and raises one combined interrupt when any pin meets the condition software has chosen for it. Each pin has its own control word, and a four-bit mode code inside it picks between no detection, a level (high or low) or an edge (rising, falling or either). A detected condition sets that pin's bit in a shared, sticky status word. The interrupt output stays high for as long as any status bit is set.

Software uses a simple register bus: word-aligned writes configure a pin's mode or clear status bits, and reads return a control word or the status word one cycle later. Status bits are cleared by writing ones to them; zeros leave them untouched. Edge detection keeps the previous sampled value of each pin. That memory only follows the pin while an edge mode is active, and it is reloaded whenever the pin's control word is written, so enabling a pin never reports a transition that happened while it was off.

The bus and pin interfaces are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure: a write or read strobe takes effect in the cycle it is sampled.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset every pin's mode is 0, every status bit is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: The control word of pin n is at byte address n*4 (n = 0..31). Its mode code is held in bits 19:16, and all other bits are ignored on write and read as 0. A read returns the last code written, including codes with no defined meaning.
- R3: Mode 0x9 (rising) sets pin n's status bit when the pin is 0 in one cycle and 1 in the next. A 1-to-0 change does not set it.
- R4: Mode 0xA (falling) sets the status bit on a 1-to-0 change only.
- R5: Mode 0xB (either edge) sets the status bit on every change of the pin.
- R6: Mode 0xC (high level) and mode 0x8 (low level) set the status bit in every cycle the pin holds that level, so the bit comes back after a clear while the level persists.
- R7: The status word is at address 0xA0, with bit n belonging to pin n. Writing it clears each bit written as 1 and leaves each bit written as 0 unchanged. Without a clear, a set bit stays set.
- R8: When a pin's condition holds in the same cycle that its status bit is cleared, the bit stays set.
- R9: `irq_out` is 1 exactly when at least one status bit is 1.
- R10: Mode 0x0 and every code other than 0x8, 0x9, 0xA, 0xB and 0xC disable detection for that pin. Writing 0 to a control word stops further sets for that pin.
- R11: A pin change that occurs while detection is disabled, followed by a write that enables an edge mode, does not set the status bit. A later real edge does set it.
- R12: A read strobe updates `bus_rdata` at the next clock edge. Reads of unmapped or unaligned addresses return 0, and writes to them change no control word or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt, OR of all status bits |

## Verification
Two cases are hard to reach from the ports. The first is a stale edge memory: a pin must change while its detection is off, and only afterwards be armed in an edge mode. The stimulus raises a pin with mode 0, waits, writes a rising-edge code to it, and then confirms that no status bit appears until the pin really goes low and high again. The second is a set colliding with a clear: a level pin is held at its active level while software writes all ones to the status word, so that its set and its clear land in the same cycle. A behavioural model in the bench follows every strobe and pin level and checks the interrupt and the read data on each clock.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_BOTH = 4'hB,
    MODE_HIGH = 4'hC
  } irq_mode_e;

  function automatic logic mode_is_edge(input logic [MODE_W-1:0] m);
    return (m == MODE_RISE) || (m == MODE_FALL) || (m == MODE_BOTH);
  endfunction

endpackage

// File: rtl/pin_irq_cond.sv
module pin_irq_cond
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              reload_i,
  output logic              hit_o
);

  logic prev_q;
  logic track;

  assign track = reload_i | mode_is_edge(mode_i);

  // previous level follows the pin only while edges are watched, and is
  // reloaded on any write to this pin's control word
  always_ff @(posedge clk) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (track) prev_q <= pin_i;
  end

  always_comb begin
    case (mode_i)
      MODE_LOW:  hit_o = ~pin_i;
      MODE_HIGH: hit_o = pin_i;
      MODE_RISE: hit_o = pin_i & ~prev_q;
      MODE_FALL: hit_o = ~pin_i & prev_q;
      MODE_BOTH: hit_o = pin_i ^ prev_q;
      default:   hit_o = 1'b0;
    endcase
  end

  // R6: a held level keeps producing hits
  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit_o) && $stable(mode_i) && $stable(pin_i) &&
     (mode_i == MODE_HIGH || mode_i == MODE_LOW)) |-> hit_o);

  // R3: one edge gives one hit while the pin stays still
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && mode_is_edge(mode_i) && !reload_i) |=>
      !(hit_o && $stable(pin_i) && $stable(mode_i)));

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flags_o,
  output logic             irq_o
);

  logic [NPINS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

  // R8: a set in the clearing cycle survives
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R7: a cleared bit without a concurrent set drops
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  // R7: no bit rises without a set, and none falls without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0) &&
              ((~flags_q & $past(flags_q) & ~$past(clr_i)) == '0)));

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MODE_LSB = 16,
  parameter int STS_ADDR = 'hA0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr_en,
  input  logic                          bus_rd_en,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NPINS-1:0]              flags_i,
  output logic [NPINS-1:0][MODE_W-1:0]  mode_o,
  output logic [NPINS-1:0]              ctrl_we_o,
  output logic [NPINS-1:0]              sts_clr_o
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [ADDR_W:0]   CTRL_END = (ADDR_W+1)'(NPINS * 4);
  localparam logic [ADDR_W-1:0] STS_A    = ADDR_W'(STS_ADDR);

  logic             ctrl_hit;
  logic             sts_hit;
  logic [IDX_W-1:0] idx;
  logic [NPINS-1:0][MODE_W-1:0] mode_q;

  assign ctrl_hit = ({1'b0, bus_addr} < CTRL_END) && (bus_addr[1:0] == 2'b00);
  assign sts_hit  = (bus_addr == STS_A);
  assign idx      = bus_addr[IDX_W+1:2];

  for (genvar g = 0; g < NPINS; g++) begin : g_ctrl
    assign ctrl_we_o[g] = bus_wr_en && ctrl_hit && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)            mode_q[g] <= '0;
      else if (ctrl_we_o[g]) mode_q[g] <= bus_wdata[MODE_LSB +: MODE_W];
    end
  end

  assign mode_o    = mode_q;
  assign sts_clr_o = (bus_wr_en && sts_hit) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      if (ctrl_hit)     bus_rdata <= DATA_W'(mode_q[idx]) << MODE_LSB;
      else if (sts_hit) bus_rdata <= DATA_W'(flags_i);
      else              bus_rdata <= '0;
    end
  end

  // R12: unmapped reads return zero
  p_unmapped_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !ctrl_hit && !sts_hit) |=> (bus_rdata == '0));

  // R2: a control write lands in the addressed pin's mode
  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && ctrl_hit) |=>
      (mode_q[$past(idx)] == $past(bus_wdata[MODE_LSB +: MODE_W])));

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import pin_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MODE_LSB = 16,
  parameter int STS_ADDR = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq_out
);

  logic [NPINS-1:0][MODE_W-1:0] mode;
  logic [NPINS-1:0]             ctrl_we;
  logic [NPINS-1:0]             sts_clr;
  logic [NPINS-1:0]             hit;
  logic [NPINS-1:0]             flags;

  pin_irq_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MODE_LSB(MODE_LSB), .STS_ADDR(STS_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flags_i(flags), .mode_o(mode), .ctrl_we_o(ctrl_we), .sts_clr_o(sts_clr)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_irq_cond u_cond (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in[g]),
      .mode_i(mode[g]), .reload_i(ctrl_we[g]), .hit_o(hit[g])
    );
  end

  pin_irq_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(sts_clr),
    .flags_o(flags), .irq_o(irq_out)
  );

  // R9: the interrupt only drops after a bus write
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(bus_wr_en));

  // R9: the interrupt only rises when some pin hit
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(hit) != '0));

endmodule

// File: tb/tb_pin_irq_detector.sv
`timescale 1ns/1ps
module tb_pin_irq_detector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_irq_detector dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [3:0]  m_mode [32];
  logic [31:0] m_prev, m_flags, m_rdata;

  always @(posedge clk) begin
    logic [31:0] nset, clr;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_mode[i] = 4'h0;
      m_prev = '0; m_flags = '0; m_rdata = '0;
    end else begin
      nset = '0;
      for (int i = 0; i < 32; i++) begin
        case (m_mode[i])
          4'h8: nset[i] = !pin_in[i];
          4'h9: nset[i] = pin_in[i] && !m_prev[i];
          4'hA: nset[i] = !pin_in[i] && m_prev[i];
          4'hB: nset[i] = pin_in[i] != m_prev[i];
          4'hC: nset[i] = pin_in[i];
          default: nset[i] = 1'b0;
        endcase
      end
      clr = (bus_wr_en && bus_addr == 8'hA0) ? bus_wdata : 32'h0;
      if (bus_rd_en) begin
        if (bus_addr < 8'h80 && bus_addr[1:0] == 2'b00)
          m_rdata = {12'h0, m_mode[bus_addr[6:2]], 16'h0};
        else if (bus_addr == 8'hA0)
          m_rdata = m_flags;
        else
          m_rdata = '0;
      end
      for (int i = 0; i < 32; i++) begin
        bit wrc;
        wrc = bus_wr_en && (bus_addr == 8'(i * 4));
        if (wrc || m_mode[i] == 4'h9 || m_mode[i] == 4'hA || m_mode[i] == 4'hB)
          m_prev[i] = pin_in[i];
        if (wrc) m_mode[i] = bus_wdata[19:16];
      end
      m_flags = (m_flags & ~clr) | nset;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 irq vs model", {31'h0, irq_out}, {31'h0, |m_flags});
      check("R12 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'h0, irq_out}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd_chk("R1 ctrl5 after reset", 8'h14, 32'h0);
    rd_chk("R1 status after reset", 8'hA0, 32'h0);

    // R2 mode field placement
    wr(8'h0C, 32'hA5A9_5A5A);
    rd_chk("R2 ctrl3 readback", 8'h0C, 32'h0009_0000);

    // R3 rising edge on pin 3
    pin_in[3] = 1'b1; idle(2);
    rd_chk("R3 rise sets bit3", 8'hA0, 32'h0000_0008);
    check("R9 irq high", {31'h0, irq_out}, 32'h1);
    wr(8'hA0, 32'h8);
    rd_chk("R7 clear bit3", 8'hA0, 32'h0);
    pin_in[3] = 1'b0; idle(2);
    rd_chk("R3 fall ignored", 8'hA0, 32'h0);
    check("R9 irq low", {31'h0, irq_out}, 32'h0);

    // R4 falling on pin 4
    wr(8'h10, 32'h000A_0000);
    pin_in[4] = 1'b1; idle(2);
    rd_chk("R4 rise ignored", 8'hA0, 32'h0);
    pin_in[4] = 1'b0; idle(2);
    rd_chk("R4 fall sets bit4", 8'hA0, 32'h0000_0010);

    // R5 either edge on pin 6
    wr(8'h18, 32'h000B_0000);
    pin_in[6] = 1'b1; idle(2);
    rd_chk("R5 rise sets bit6", 8'hA0, 32'h0000_0050);
    wr(8'hA0, 32'h40);
    pin_in[6] = 1'b0; idle(2);
    rd_chk("R5 fall sets bit6", 8'hA0, 32'h0000_0050);
    wr(8'hA0, 32'h40);
    rd_chk("R7 zeros leave bit4", 8'hA0, 32'h0000_0010);
    wr(8'hA0, 32'hFFFF_FFFF);
    rd_chk("R7 clear all", 8'hA0, 32'h0);

    // R6 levels on pins 7 and 8
    wr(8'h1C, 32'h000C_0000);
    pin_in[7] = 1'b1; idle(2);
    rd_chk("R6 high level sets bit7", 8'hA0, 32'h0000_0080);
    wr(8'hA0, 32'h80);
    rd_chk("R6 high level reasserts", 8'hA0, 32'h0000_0080);
    wr(8'h20, 32'h0008_0000);
    idle(1);
    rd_chk("R6 low level sets bit8", 8'hA0, 32'h0000_0180);
    // R8 set wins over clear
    wr(8'hA0, 32'hFFFF_FFFF);
    rd_chk("R8 set beats clear", 8'hA0, 32'h0000_0180);
    // R10 writing zero disables
    wr(8'h1C, 32'h0); wr(8'h20, 32'h0);
    wr(8'hA0, 32'hFFFF_FFFF);
    idle(2);
    rd_chk("R10 disabled pins stay clear", 8'hA0, 32'h0);
    check("R9 irq low after clear", {31'h0, irq_out}, 32'h0);

    // R10 unlisted codes on pin 9
    wr(8'h24, 32'h000D_0000);
    rd_chk("R2 unlisted code readback", 8'h24, 32'h000D_0000);
    pin_in[9] = 1'b1; idle(2); pin_in[9] = 1'b0; idle(2);
    rd_chk("R10 code D inert", 8'hA0, 32'h0);
    wr(8'h24, 32'h000F_0000);
    pin_in[9] = 1'b1; idle(2); pin_in[9] = 1'b0; idle(2);
    rd_chk("R10 code F inert", 8'hA0, 32'h0);

    // R11 no false edge when arming pin 10
    pin_in[10] = 1'b1; idle(2);
    wr(8'h28, 32'h0009_0000);
    idle(3);
    rd_chk("R11 no stale edge", 8'hA0, 32'h0);
    pin_in[10] = 1'b0; idle(2); pin_in[10] = 1'b1; idle(2);
    rd_chk("R11 real edge after arm", 8'hA0, 32'h0000_0400);
    wr(8'hA0, 32'hFFFF_FFFF);

    // R12 unmapped and unaligned accesses
    rd_chk("R12 read 0x84", 8'h84, 32'h0);
    rd_chk("R12 read unaligned", 8'h02, 32'h0);
    wr(8'h02, 32'h0009_0000);
    rd_chk("R12 unaligned write ignored", 8'h00, 32'h0);
    wr(8'h84, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped write ignored", 8'hA0, 32'h0);

    idle(2);
    finish_run();
  end

endmodule